// File: doc/BRIEF.md
# Flash Write Buffer Loader

This block runs the buffered-program handshake of a NOR flash command front end. A host starts a sequence by writing the load opcode to an address inside the target erase block. While no earlier buffer is still being programmed, an extended status bit reads 1 to show that a buffer is free. The host then writes a unit count, then exactly that many data writes, and then a confirm byte. On a good confirm the collected bytes go to a programming engine. The engine takes one byte per cycle over a valid/ready handshake, in the order the host wrote them.

The host may write bytes (narrow bus) or 16-bit words (wide bus). The loader checks the count against the 32-byte buffer. It checks that every data write lands in the block named by the opcode write and inside one aligned 32-byte window. It also checks the confirm byte. A failed check drops the sequence and raises a sticky error flag. The flags stay set until the next accepted load opcode. No flash array is modelled here. The engine side is a plain stream of byte address and data.

Top module: `fwb_loader`

## Requirements
- R1: After reset, xsr_avail and sts_ready are 1, err_prog and err_erase are 0, and prog_valid is 0.
- R2: Outside a sequence, a write whose low data byte is E8h starts a sequence and clears both error flags. Any other write there has no effect.
- R3: The first write after E8h carries the count as N-1 in its low byte. N may be at most 32 on a narrow bus (wide_mode=0) and at most 16 on a wide bus (wide_mode=1). A larger value ends the sequence with err_prog=1 and err_erase unchanged, and nothing is programmed.
- R4: Exactly N data writes follow the count. A narrow write stores bus_wdata[7:0] at its byte address. A wide write stores bus_wdata[7:0] at the even byte address and bus_wdata[15:8] at the next odd address (bus_addr[0] is ignored). The buffer never holds more than 32 bytes.
- R5: The first data write must lie in the same erase block as the E8h write. The block is bus_addr[22:17]. Otherwise the sequence ends with err_prog=1 and nothing is programmed.
- R6: Every later data write must lie in the same aligned 32-byte window (bus_addr[22:5]) as the first data write. Otherwise the sequence ends with err_prog=1.
- R7: After the last data write, a write with low byte D0h starts programming. Any other byte discards the buffer, sets both err_prog and err_erase to 1, and nothing is programmed.
- R8: xsr_avail and sts_ready fall in the cycle after the confirm is taken. They rise again in the cycle after the last byte's handshake.
- R9: Programming presents bytes in write order. prog_addr is the window base plus the stored offset. There is one byte per valid/ready handshake. prog_valid, prog_addr and prog_data hold steady while prog_ready is 0.
- R10: Bus writes made while the buffer is being programmed, including E8h, are ignored.
- R11: When programming ends, the loader accepts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | One-cycle host write strobe |
| bus_addr | input | 23 | Host byte address |
| bus_wdata | input | 16 | Host write data; commands use bits 7:0 |
| wide_mode | input | 1 | 1 = 16-bit host bus, 0 = 8-bit |
| prog_ready | input | 1 | Programming engine accepts a byte |
| xsr_avail | output | 1 | Extended status: write buffer available |
| sts_ready | output | 1 | Status: programming engine idle |
| err_prog | output | 1 | Sticky program error flag |
| err_erase | output | 1 | Sticky erase error flag (set on bad confirm) |
| prog_valid | output | 1 | Byte offered to the programming engine |
| prog_addr | output | 23 | Byte address of the offered byte |
| prog_data | output | 8 | Offered byte |

## Verification
Every host write is taken at a rising edge. The state it causes shows at the outputs one edge later: error flags, busy flags and the first prog_valid after a confirm. The bench drives each write between falling edges. It then samples at the next falling edge, which comes after the edge that consumed the write.

On the engine side, prog_ready is changed only at falling edges. A byte counts as taken when valid and ready are both high at a falling edge. The bench records the falling-edge cycle of the last handshake and the cycle in which sts_ready rises. These two must be exactly one cycle apart. While ready is low, the bench compares the offered byte between consecutive falling edges.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COUNT   = 3'd1,
    ST_DATA    = 3'd2,
    ST_CONFIRM = 3'd3,
    ST_DRAIN   = 3'd4
  } fwb_state_t;

  localparam logic [7:0] OP_LOAD    = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;

endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int BLK_LOG   = 17,
  parameter int BUF_BYTES = 32,
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int CNT_W    = OFF_W + 1,
  localparam int WIN_W    = ADDR_W - OFF_W,
  localparam int BLK_W    = ADDR_W - BLK_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              wide_mode,
  input  logic              drain_last,
  output logic              push_en,
  output logic              push_wide,
  output logic [OFF_W-1:0]  push_off,
  output logic [15:0]       push_data,
  output logic              buf_clear,
  output logic              drain_en,
  output logic [WIN_W-1:0]  win_base,
  output logic              err_prog,
  output logic              err_erase
);

  localparam logic [7:0] LIM_NARROW = 8'(BUF_BYTES - 1);
  localparam logic [7:0] LIM_WIDE   = 8'(BUF_BYTES / 2 - 1);

  fwb_state_t        st_q, st_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic              wide_q, wide_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              first_q, first_d;
  logic              errp_q, errp_d;
  logic              erre_q, erre_d;

  logic [7:0]        cmd_byte;
  logic [BLK_W-1:0]  addr_blk;
  logic [WIN_W-1:0]  addr_win;
  logic [7:0]        cnt_lim;
  logic              in_range;

  assign cmd_byte = bus_wdata[7:0];
  assign addr_blk = bus_addr[ADDR_W-1:BLK_LOG];
  assign addr_win = bus_addr[ADDR_W-1:OFF_W];
  assign cnt_lim  = wide_mode ? LIM_WIDE : LIM_NARROW;
  // first data write is tied to the block, later ones to the window
  assign in_range = first_q ? (addr_blk == blk_q) : (addr_win == win_q);

  // next-state process
  always_comb begin
    st_d      = st_q;
    blk_d     = blk_q;
    win_d     = win_q;
    wide_d    = wide_q;
    left_d    = left_q;
    first_d   = first_q;
    errp_d    = errp_q;
    erre_d    = erre_q;
    push_en   = 1'b0;
    buf_clear = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (bus_we && cmd_byte == OP_LOAD) begin
          st_d   = ST_COUNT;
          blk_d  = addr_blk;
          errp_d = 1'b0;
          erre_d = 1'b0;
        end
      end
      ST_COUNT: begin
        if (bus_we) begin
          if (cmd_byte > cnt_lim) begin
            st_d   = ST_IDLE;
            errp_d = 1'b1;
          end else begin
            st_d      = ST_DATA;
            wide_d    = wide_mode;
            left_d    = CNT_W'(cmd_byte[OFF_W-1:0]) + CNT_W'(1);
            first_d   = 1'b1;
            buf_clear = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (bus_we) begin
          if (!in_range) begin
            st_d   = ST_IDLE;
            errp_d = 1'b1;
          end else begin
            push_en = 1'b1;
            first_d = 1'b0;
            if (first_q) win_d = addr_win;
            left_d = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) st_d = ST_CONFIRM;
          end
        end
      end
      ST_CONFIRM: begin
        if (bus_we) begin
          if (cmd_byte == OP_CONFIRM) begin
            st_d = ST_DRAIN;
          end else begin
            st_d   = ST_IDLE;
            errp_d = 1'b1;
            erre_d = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (drain_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      blk_q   <= '0;
      win_q   <= '0;
      wide_q  <= 1'b0;
      left_q  <= '0;
      first_q <= 1'b0;
      errp_q  <= 1'b0;
      erre_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      blk_q   <= blk_d;
      win_q   <= win_d;
      wide_q  <= wide_d;
      left_q  <= left_d;
      first_q <= first_d;
      errp_q  <= errp_d;
      erre_q  <= erre_d;
    end
  end

  assign push_wide = wide_q;
  assign push_off  = wide_q ? {bus_addr[OFF_W-1:1], 1'b0} : bus_addr[OFF_W-1:0];
  assign push_data = bus_wdata;
  assign drain_en  = (st_q == ST_DRAIN);
  assign win_base  = win_q;
  assign err_prog  = errp_q;
  assign err_erase = erre_q;

  // R3: an oversized count returns to idle with the program error set
  p_count_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT && bus_we && cmd_byte > cnt_lim) |=> (st_q == ST_IDLE && err_prog));

  // R7: a wrong confirm byte raises both error flags and never drains
  p_bad_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONFIRM && bus_we && cmd_byte != OP_CONFIRM)
      |=> (st_q == ST_IDLE && err_prog && err_erase));

  // R8: programming only ever begins straight out of the confirm step
  p_drain_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_en) |-> $past(st_q) == ST_CONFIRM);

  // R10: host traffic cannot pull the loader out of the drain
  p_drain_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && !drain_last) |=> st_q == ST_DRAIN);

endmodule

// File: rtl/fwb_buf.sv
module fwb_buf #(
  parameter int DEPTH  = 32,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int PTR_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push_en,
  input  logic             push_wide,
  input  logic [OFF_W-1:0] push_off,
  input  logic [15:0]      push_data,
  input  logic             drain_en,
  input  logic             prog_ready,
  output logic             prog_valid,
  output logic [OFF_W-1:0] out_off,
  output logic [7:0]       out_data,
  output logic             drain_last
);

  logic [OFF_W-1:0] off_mem [DEPTH];
  logic [7:0]       dat_mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [DEPTH-1:0] we_lo, we_hi;
  logic [PTR_W-1:0] wr_plus1;
  logic             take;

  assign wr_plus1 = wr_q + PTR_W'(1);

  // per-entry write enables: low byte at the fill pointer, high byte next
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_we
    assign we_lo[gi] = push_en && (wr_q == PTR_W'(gi));
    assign we_hi[gi] = push_en && push_wide && (wr_plus1 == PTR_W'(gi));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_lo[i]) begin
        off_mem[i] <= push_off;
        dat_mem[i] <= push_data[7:0];
      end else if (we_hi[i]) begin
        off_mem[i] <= push_off | OFF_W'(1);
        dat_mem[i] <= push_data[15:8];
      end
    end
  end

  assign prog_valid = drain_en && (rd_q != wr_q);
  assign take       = prog_valid && prog_ready;
  assign drain_last = take && (rd_q + PTR_W'(1) == wr_q);
  assign out_off    = off_mem[rd_q[OFF_W-1:0]];
  assign out_data   = dat_mem[rd_q[OFF_W-1:0]];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (clear) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      if (push_en) wr_d = wr_q + (push_wide ? PTR_W'(2) : PTR_W'(1));
      if (take)    rd_d = rd_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  // R4: a push never runs past the buffer
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (32'(wr_q) + (push_wide ? 32'd2 : 32'd1)) <= 32'(DEPTH));

  // R9: an offered byte stays put until the engine takes it
  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !prog_ready) |=> (prog_valid && $stable(out_off) && $stable(out_data)));

endmodule

// File: rtl/fwb_loader.sv
module fwb_loader
  import fwb_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int BLK_LOG   = 17,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              wide_mode,
  input  logic              prog_ready,
  output logic              xsr_avail,
  output logic              sts_ready,
  output logic              err_prog,
  output logic              err_erase,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data
);

  localparam int OFF_W = $clog2(BUF_BYTES);
  localparam int WIN_W = ADDR_W - OFF_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             push_en, push_wide, buf_clear, drain_en, drain_last;
  logic [OFF_W-1:0] push_off, out_off;
  logic [15:0]      push_data;
  logic [WIN_W-1:0] win_base;

  fwb_ctrl #(
    .ADDR_W    (ADDR_W),
    .BLK_LOG   (BLK_LOG),
    .BUF_BYTES (BUF_BYTES)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .wide_mode  (wide_mode),
    .drain_last (drain_last),
    .push_en    (push_en),
    .push_wide  (push_wide),
    .push_off   (push_off),
    .push_data  (push_data),
    .buf_clear  (buf_clear),
    .drain_en   (drain_en),
    .win_base   (win_base),
    .err_prog   (err_prog),
    .err_erase  (err_erase)
  );

  fwb_buf #(
    .DEPTH (BUF_BYTES)
  ) i_buf (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .clear      (buf_clear),
    .push_en    (push_en),
    .push_wide  (push_wide),
    .push_off   (push_off),
    .push_data  (push_data),
    .drain_en   (drain_en),
    .prog_ready (prog_ready),
    .prog_valid (prog_valid),
    .out_off    (out_off),
    .out_data   (out_data_w),
    .drain_last (drain_last)
  );

  logic [7:0] out_data_w;

  assign prog_addr = {win_base, out_off};
  assign prog_data = out_data_w;
  assign xsr_avail = !drain_en;
  assign sts_ready = !drain_en;

endmodule

// File: tb/test_fwb_loader.sv
module test_fwb_loader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [22:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        wide_mode;
  logic        prog_ready;
  logic        xsr_avail, sts_ready, err_prog, err_erase, prog_valid;
  logic [22:0] prog_addr;
  logic [7:0]  prog_data;

  always #2 clk = ~clk;

  fwb_loader i_fwb_loader (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wide_mode(wide_mode), .prog_ready(prog_ready),
    .xsr_avail(xsr_avail), .sts_ready(sts_ready), .err_prog(err_prog),
    .err_erase(err_erase), .prog_valid(prog_valid), .prog_addr(prog_addr),
    .prog_data(prog_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [22:0] cap_addr [64];
  logic [7:0]  cap_data [64];
  int          cap_n = 0;
  int          last_hs_cyc = 0;
  int          rise_cyc = 0;
  logic [22:0] exp_addr [64];
  logic [7:0]  exp_data [64];
  int          exp_n = 0;

  bit          hold_pend = 1'b0;
  logic [22:0] hold_addr;
  logic [7:0]  hold_data;
  logic        prev_sts = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // engine stub and observer, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    prog_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
    if (hold_pend) begin
      chk("R9 offer held (valid)", {31'd0, prog_valid}, 32'd1);
      chk("R9 offer held (addr)", {9'd0, prog_addr}, {9'd0, hold_addr});
      chk("R9 offer held (data)", {24'd0, prog_data}, {24'd0, hold_data});
    end
    hold_pend = prog_valid && !prog_ready;
    hold_addr = prog_addr;
    hold_data = prog_data;
    if (prog_valid && prog_ready && cap_n < 64) begin
      cap_addr[cap_n] = prog_addr;
      cap_data[cap_n] = prog_data;
      cap_n++;
      last_hs_cyc = cyc;
    end
    if (sts_ready && !prev_sts) rise_cyc = cyc;
    prev_sts = sts_ready;
  end

  task automatic bw(input logic [22:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic clear_exp();
    exp_n = 0;
    cap_n = 0;
  endtask

  task automatic add_exp(input logic [22:0] a, input logic [7:0] d);
    exp_addr[exp_n] = a;
    exp_data[exp_n] = d;
    exp_n++;
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 400 && !sts_ready; i++) @(negedge clk);
    @(negedge clk);
    chk({tag, " idle again"}, {31'd0, sts_ready}, 32'd1);
    chk("R8 ready rises one cycle after last handshake", rise_cyc, last_hs_cyc + 1);
  endtask

  task automatic cmp_drain(input string tag);
    chk({tag, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk({tag, " addr"}, {9'd0, cap_addr[i]}, {9'd0, exp_addr[i]});
      chk({tag, " data"}, {24'd0, cap_data[i]}, {24'd0, exp_data[i]});
    end
  endtask

  task automatic expect_quiet(input string tag);
    repeat (3) @(negedge clk);
    chk({tag, " no programming"}, {31'd0, prog_valid}, 32'd0);
    chk({tag, " nothing drained"}, cap_n, 0);
    chk({tag, " buffer available"}, {31'd0, xsr_avail}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 xsr_avail", {31'd0, xsr_avail}, 32'd1);
    chk("R1 sts_ready", {31'd0, sts_ready}, 32'd1);
    chk("R1 err_prog", {31'd0, err_prog}, 32'd0);
    chk("R1 err_erase", {31'd0, err_erase}, 32'd0);
    chk("R1 prog_valid", {31'd0, prog_valid}, 32'd0);
  endtask

  task automatic t_idle_ignore();
    clear_exp();
    bw(23'h040000, 16'h00D0);
    bw(23'h040001, 16'h0000);
    bw(23'h040000, 16'h00D0);
    expect_quiet("R2 idle writes");
    chk("R2 idle writes ready", {31'd0, sts_ready}, 32'd1);
    chk("R2 idle writes no error", {30'd0, err_prog, err_erase}, 32'd0);
  endtask

  task automatic t_narrow_order();
    clear_exp();
    bw(23'h040000, 16'h00E8);
    chk("R2 buffer available after load opcode", {31'd0, xsr_avail}, 32'd1);
    bw(23'h040000, 16'h0003);
    bw(23'h040015, 16'h0011); add_exp(23'h040015, 8'h11);
    bw(23'h040002, 16'h0022); add_exp(23'h040002, 8'h22);
    bw(23'h04001F, 16'h0033); add_exp(23'h04001F, 8'h33);
    bw(23'h040015, 16'h0044); add_exp(23'h040015, 8'h44);
    bw(23'h040000, 16'h00D0);
    chk("R8 xsr_avail low after confirm", {31'd0, xsr_avail}, 32'd0);
    chk("R8 sts_ready low after confirm", {31'd0, sts_ready}, 32'd0);
    wait_idle("R11 narrow");
    cmp_drain("R4 R9 narrow order");
  endtask

  task automatic t_narrow_full_stall();
    clear_exp();
    stall_en = 1'b1;
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h001F);
    for (int i = 0; i < 32; i++) begin
      bw(23'h040020 + 23'(i), 16'(i * 7 + 1));
      add_exp(23'h040020 + 23'(i), 8'(i * 7 + 1));
    end
    bw(23'h040000, 16'h00D0);
    wait_idle("R3 full narrow");
    cmp_drain("R3 R9 32-byte narrow");
    stall_en = 1'b0;
  endtask

  task automatic t_wide();
    clear_exp();
    wide_mode = 1'b1;
    bw(23'h060000, 16'h00E8);
    bw(23'h060000, 16'h0002);
    bw(23'h060044, 16'hA1B2); add_exp(23'h060044, 8'hB2); add_exp(23'h060045, 8'hA1);
    bw(23'h060041, 16'hC3D4); add_exp(23'h060040, 8'hD4); add_exp(23'h060041, 8'hC3);
    bw(23'h06005E, 16'h0102); add_exp(23'h06005E, 8'h02); add_exp(23'h06005F, 8'h01);
    bw(23'h060000, 16'h00D0);
    wait_idle("R4 wide");
    cmp_drain("R4 wide split");
    clear_exp();
    bw(23'h060000, 16'h00E8);
    bw(23'h060000, 16'h000F);
    for (int i = 0; i < 16; i++) begin
      bw(23'h060020 + 23'(2 * i), {8'(i), 8'(8'hF0 - i)});
      add_exp(23'h060020 + 23'(2 * i), 8'(8'hF0 - i));
      add_exp(23'h060021 + 23'(2 * i), 8'(i));
    end
    bw(23'h060000, 16'h00D0);
    wait_idle("R3 full wide");
    cmp_drain("R3 16-word wide");
    wide_mode = 1'b0;
  endtask

  task automatic t_count_over();
    clear_exp();
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h0020);
    chk("R3 narrow over-count err_prog", {31'd0, err_prog}, 32'd1);
    chk("R3 narrow over-count err_erase", {31'd0, err_erase}, 32'd0);
    bw(23'h040000, 16'h0000);
    bw(23'h040000, 16'h00D0);
    expect_quiet("R3 narrow over-count");
    wide_mode = 1'b1;
    bw(23'h040000, 16'h00E8);
    chk("R2 load clears err_prog", {31'd0, err_prog}, 32'd0);
    bw(23'h040000, 16'h0010);
    chk("R3 wide over-count err_prog", {31'd0, err_prog}, 32'd1);
    bw(23'h040000, 16'h00D0);
    expect_quiet("R3 wide over-count");
    wide_mode = 1'b0;
  endtask

  task automatic t_block_cross();
    clear_exp();
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h0000);
    bw(23'h060000, 16'h0055);
    chk("R5 other block err_prog", {31'd0, err_prog}, 32'd1);
    bw(23'h060000, 16'h00D0);
    expect_quiet("R5 other block");
  endtask

  task automatic t_window();
    clear_exp();
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h0001);
    bw(23'h040000, 16'h0066);
    bw(23'h040020, 16'h0077);
    chk("R6 window cross err_prog", {31'd0, err_prog}, 32'd1);
    bw(23'h040000, 16'h00D0);
    expect_quiet("R6 window cross");
    clear_exp();
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h0001);
    bw(23'h040020, 16'h0066); add_exp(23'h040020, 8'h66);
    bw(23'h04003F, 16'h0077); add_exp(23'h04003F, 8'h77);
    bw(23'h040000, 16'h00D0);
    wait_idle("R6 window edge");
    cmp_drain("R6 window edge bytes");
    chk("R6 window edge no error", {31'd0, err_prog}, 32'd0);
  endtask

  task automatic t_bad_confirm();
    clear_exp();
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h0000);
    bw(23'h040004, 16'h0099);
    bw(23'h040000, 16'h00FF);
    chk("R7 bad confirm err_prog", {31'd0, err_prog}, 32'd1);
    chk("R7 bad confirm err_erase", {31'd0, err_erase}, 32'd1);
    expect_quiet("R7 bad confirm");
    bw(23'h040000, 16'h00E8);
    chk("R2 load clears both flags", {30'd0, err_prog, err_erase}, 32'd0);
    bw(23'h040000, 16'h0000);
    bw(23'h040004, 16'h0099);
    bw(23'h040000, 16'h00D0);
    wait_idle("R11 after bad confirm");
  endtask

  task automatic t_drain_busy();
    clear_exp();
    stall_en = 1'b1;
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h0007);
    for (int i = 0; i < 8; i++) begin
      bw(23'h040040 + 23'(i), 16'(8'h30 + i));
      add_exp(23'h040040 + 23'(i), 8'(8'h30 + i));
    end
    bw(23'h040000, 16'h00D0);
    bw(23'h040000, 16'h00E8);
    bw(23'h040000, 16'h0000);
    chk("R10 still busy after writes", {31'd0, sts_ready}, 32'd0);
    wait_idle("R10 drain");
    cmp_drain("R10 drain unaffected");
    bw(23'h040040, 16'h0011);
    bw(23'h040000, 16'h00D0);
    repeat (3) @(negedge clk);
    chk("R10 ignored opcode started nothing", {31'd0, prog_valid}, 32'd0);
    chk("R10 no extra bytes", cap_n, 8);
    stall_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    bus_we = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    wide_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_narrow_order();
    t_narrow_full_stall();
    t_wide();
    t_count_over();
    t_block_cross();
    t_window();
    t_bad_confirm();
    t_drain_busy();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule